// File: doc/BRIEF.md
# Reorder Buffer for In-Order Commit

This block keeps the results of instructions that ran speculatively and out of order until each one may change architectural state. The issue stage allocates one entry per instruction in program order and receives the entry index, which serves as its rename tag. Execution units later complete an entry by tag. Completion supplies a value, an address for stores, a mispredict flag for branches and a fault flag. Dependent instructions can read a completed value by tag without waiting for the register file.

Each cycle, the oldest entry retires if it has completed, and at most one entry retires per cycle. A register instruction writes its destination when it retires, and a store releases its address and data to memory when it retires. A branch that retires with its mispredict flag set pulses a redirect and discards every younger entry. A faulting entry raises its exception only when it reaches the head and has completed. It makes no architectural write, and it discards itself and every younger entry.

Top module: `rob_core`

## Requirements
- R1: After reset the buffer is empty, `alloc_ready` is 1, the first tag issued is 0, and no commit output is active.
- R2: Tags are handed out in allocation order as consecutive values modulo the depth (8), starting from the slot after the last tag in use.
- R3: With 8 live entries `alloc_ready` is 0, and `alloc_valid` pulses in that state allocate nothing.
- R4: Entries retire in allocation order. The head waits until it has completed, even when younger entries have already completed.
- R5: At most one entry retires per cycle. A run of completed entries retires on consecutive cycles.
- R6: A retiring register entry (kind 2'b00) pulses `reg_we` with its destination and completed value.
- R7: A retiring store entry (kind 2'b01) pulses `st_release` with the completed address and value. It does not write a register.
- R8: `lookup_hit` is 1 with the value when the tag is live and completed. It is 0 when the tag is not yet completed or has been retired or discarded.
- R9: A retiring branch (kind 2'b10) completed with the mispredict flag pulses `redirect`, and younger entries never retire. The next tag issued is the branch tag plus 1. A correctly predicted branch retires with no output.
- R10: A completed fault raises `exc_valid` with its tag only when that entry is at the head. The faulting entry does not write, younger entries are discarded, and the next tag is the fault tag plus 1.
- R11: A completion aimed at a tag that is not live has no effect. An entry later allocated at that tag starts uncompleted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Issue requests an entry |
| alloc_kind | input | 2 | 00 register, 01 store, 10 branch |
| alloc_dest | input | 5 | Destination register number |
| alloc_ready | output | 1 | An allocation is accepted this cycle |
| alloc_tag | output | 3 | Tag given to the allocation |
| done_valid | input | 1 | A unit completes an entry |
| done_tag | input | 3 | Tag being completed |
| done_value | input | 32 | Result, or store data |
| done_addr | input | 32 | Store address |
| done_mispredict | input | 1 | Branch was mispredicted |
| done_fault | input | 1 | Instruction faulted |
| lookup_tag | input | 3 | Operand tag to read |
| lookup_hit | output | 1 | Tag live and completed |
| lookup_value | output | 32 | Value of that entry |
| reg_we | output | 1 | Register write at retire |
| reg_dest | output | 5 | Register written |
| reg_value | output | 32 | Value written |
| st_release | output | 1 | Store released at retire |
| st_addr | output | 32 | Store address |
| st_data | output | 32 | Store data |
| redirect | output | 1 | Mispredicted branch retired |
| exc_valid | output | 1 | Exception at head |
| exc_tag | output | 3 | Tag of faulting entry |

## Verification
The assertions assume that each live tag is completed at most once, that the branch flag is set only on branch entries, and that requesters respect `alloc_ready` before counting an allocation as taken. The stimulus completes each live entry once and retries nothing blindly. It drives `alloc_valid` against a full buffer only on purpose, to show that the pulse is dropped. It sends a completion to a dead tag only in the R11 case.

// File: rtl/rob_pkg.sv
package rob_pkg;
  typedef enum logic [1:0] {
    KIND_REG    = 2'b00,
    KIND_STORE  = 2'b01,
    KIND_BRANCH = 2'b10
  } rob_kind_e;
endpackage

// File: rtl/rob_track.sv
module rob_track #(
  parameter int DEPTH = 8,
  localparam int TW = $clog2(DEPTH),
  localparam int CW = TW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  input  logic          squash,
  output logic [TW-1:0] head,
  output logic [TW-1:0] tail,
  output logic [CW-1:0] count,
  output logic          full
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head  <= '0;
      tail  <= '0;
      count <= '0;
    end else if (squash) begin
      head  <= head + 1'b1;
      tail  <= head + 1'b1;
      count <= '0;
    end else begin
      if (pop)  head <= head + 1'b1;
      if (push) tail <= tail + 1'b1;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign full = (count == CW'(DEPTH));
endmodule

// File: rtl/rob_slots.sv
module rob_slots
  import rob_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int XLEN  = 32,
  parameter int RW    = 5,
  localparam int TW = $clog2(DEPTH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [TW-1:0]   wr_idx,
  input  rob_kind_e       wr_kind,
  input  logic [RW-1:0]   wr_dest,
  input  logic            cpl_en,
  input  logic [TW-1:0]   cpl_idx,
  input  logic [XLEN-1:0] cpl_value,
  input  logic [XLEN-1:0] cpl_addr,
  input  logic            cpl_misp,
  input  logic            cpl_fault,
  input  logic [TW-1:0]   hd_idx,
  output rob_kind_e       hd_kind,
  output logic [RW-1:0]   hd_dest,
  output logic [XLEN-1:0] hd_value,
  output logic [XLEN-1:0] hd_addr,
  output logic            hd_ready,
  output logic            hd_misp,
  output logic            hd_fault,
  input  logic [TW-1:0]   lk_idx,
  output logic            lk_ready,
  output logic [XLEN-1:0] lk_value
);
  rob_kind_e       kind_q  [DEPTH];
  logic [RW-1:0]   dest_q  [DEPTH];
  logic [XLEN-1:0] value_q [DEPTH];
  logic [XLEN-1:0] addr_q  [DEPTH];
  logic [DEPTH-1:0] ready_q, misp_q, fault_q;

  for (genvar s = 0; s < DEPTH; s++) begin : g_slot
    logic take, fill;
    assign take = wr_en && (wr_idx == TW'(s));
    assign fill = cpl_en && (cpl_idx == TW'(s));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        kind_q[s]  <= KIND_REG;
        dest_q[s]  <= '0;
        value_q[s] <= '0;
        addr_q[s]  <= '0;
        ready_q[s] <= 1'b0;
        misp_q[s]  <= 1'b0;
        fault_q[s] <= 1'b0;
      end else if (take) begin
        kind_q[s]  <= wr_kind;
        dest_q[s]  <= wr_dest;
        ready_q[s] <= 1'b0;
        misp_q[s]  <= 1'b0;
        fault_q[s] <= 1'b0;
      end else if (fill) begin
        value_q[s] <= cpl_value;
        addr_q[s]  <= cpl_addr;
        ready_q[s] <= 1'b1;
        misp_q[s]  <= cpl_misp;
        fault_q[s] <= cpl_fault;
      end
    end
  end

  assign hd_kind  = kind_q[hd_idx];
  assign hd_dest  = dest_q[hd_idx];
  assign hd_value = value_q[hd_idx];
  assign hd_addr  = addr_q[hd_idx];
  assign hd_ready = ready_q[hd_idx];
  assign hd_misp  = misp_q[hd_idx];
  assign hd_fault = fault_q[hd_idx];
  assign lk_ready = ready_q[lk_idx];
  assign lk_value = value_q[lk_idx];
endmodule

// File: rtl/rob_core.sv
module rob_core
  import rob_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int XLEN  = 32,
  parameter int RW    = 5,
  localparam int TW = $clog2(DEPTH),
  localparam int CW = TW + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            alloc_valid,
  input  logic [1:0]      alloc_kind,
  input  logic [RW-1:0]   alloc_dest,
  output logic            alloc_ready,
  output logic [TW-1:0]   alloc_tag,
  input  logic            done_valid,
  input  logic [TW-1:0]   done_tag,
  input  logic [XLEN-1:0] done_value,
  input  logic [XLEN-1:0] done_addr,
  input  logic            done_mispredict,
  input  logic            done_fault,
  input  logic [TW-1:0]   lookup_tag,
  output logic            lookup_hit,
  output logic [XLEN-1:0] lookup_value,
  output logic            reg_we,
  output logic [RW-1:0]   reg_dest,
  output logic [XLEN-1:0] reg_value,
  output logic            st_release,
  output logic [XLEN-1:0] st_addr,
  output logic [XLEN-1:0] st_data,
  output logic            redirect,
  output logic            exc_valid,
  output logic [TW-1:0]   exc_tag
);
  // distance of a tag from the oldest entry, in allocation order
  function automatic logic [TW-1:0] age_of(input logic [TW-1:0] tag,
                                           input logic [TW-1:0] oldest);
    return tag - oldest;
  endfunction

  function automatic logic is_live(input logic [TW-1:0] tag,
                                   input logic [TW-1:0] oldest,
                                   input logic [CW-1:0] used);
    return CW'(age_of(tag, oldest)) < used;
  endfunction

  logic [TW-1:0]   head, tail;
  logic [CW-1:0]   count;
  logic            full;
  rob_kind_e       hd_kind;
  logic [RW-1:0]   hd_dest;
  logic [XLEN-1:0] hd_value, hd_addr, lk_value;
  logic            hd_ready, hd_misp, hd_fault, lk_ready;

  // named events
  logic alloc_fire, done_live, commit_fire, squash;

  assign commit_fire = (count != '0) && hd_ready;
  assign squash      = commit_fire &&
                       (hd_fault || (hd_kind == KIND_BRANCH && hd_misp));
  assign alloc_ready = !full && !squash;
  assign alloc_fire  = alloc_valid && alloc_ready;
  assign alloc_tag   = tail;
  assign done_live   = done_valid && is_live(done_tag, head, count);

  rob_track #(.DEPTH(DEPTH)) u_track (
    .clk(clk), .rst_n(rst_n),
    .push(alloc_fire), .pop(commit_fire), .squash(squash),
    .head(head), .tail(tail), .count(count), .full(full)
  );

  rob_slots #(.DEPTH(DEPTH), .XLEN(XLEN), .RW(RW)) u_slots (
    .clk(clk), .rst_n(rst_n),
    .wr_en(alloc_fire), .wr_idx(tail), .wr_kind(rob_kind_e'(alloc_kind)),
    .wr_dest(alloc_dest),
    .cpl_en(done_live), .cpl_idx(done_tag), .cpl_value(done_value),
    .cpl_addr(done_addr), .cpl_misp(done_mispredict), .cpl_fault(done_fault),
    .hd_idx(head), .hd_kind(hd_kind), .hd_dest(hd_dest), .hd_value(hd_value),
    .hd_addr(hd_addr), .hd_ready(hd_ready), .hd_misp(hd_misp),
    .hd_fault(hd_fault),
    .lk_idx(lookup_tag), .lk_ready(lk_ready), .lk_value(lk_value)
  );

  assign lookup_hit   = lk_ready && is_live(lookup_tag, head, count);
  assign lookup_value = lk_value;

  assign reg_we     = commit_fire && !hd_fault && hd_kind == KIND_REG;
  assign reg_dest   = hd_dest;
  assign reg_value  = hd_value;
  assign st_release = commit_fire && !hd_fault && hd_kind == KIND_STORE;
  assign st_addr    = hd_addr;
  assign st_data    = hd_value;
  assign redirect   = commit_fire && !hd_fault && hd_kind == KIND_BRANCH && hd_misp;
  assign exc_valid  = commit_fire && hd_fault;
  assign exc_tag    = head;

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (full && alloc_valid && !commit_fire) |=> (count == CW'(DEPTH)));

  assert_single_retire_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({reg_we, st_release, redirect, exc_valid}));

  assert_head_advances_R4: assert property (@(posedge clk) disable iff (!rst_n)
    commit_fire |=> (head == TW'($past(head) + 1'b1)));

  assert_squash_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (redirect || exc_valid) |=> (count == '0));

  assert_empty_no_retire_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (count == '0) |-> !(reg_we || st_release || redirect || exc_valid));
endmodule

// File: tb/rob_core_test.sv
`timescale 1ns/100ps
module rob_core_test;
  logic clk = 0, rst_n = 0;
  logic alloc_valid = 0, done_valid = 0, done_mispredict = 0, done_fault = 0;
  logic [1:0] alloc_kind = 0;
  logic [4:0] alloc_dest = 0;
  logic [2:0] done_tag = 0, lookup_tag = 0, alloc_tag, exc_tag;
  logic [31:0] done_value = 0, done_addr = 0;
  logic alloc_ready, lookup_hit, reg_we, st_release, redirect, exc_valid;
  logic [31:0] lookup_value, reg_value, st_addr, st_data;
  logic [4:0] reg_dest;

  int total = 0, bad = 0, cycles = 0;
  int next_tag = 0;
  logic done_flag = 0;

  typedef struct { int kind; int a; int b; } ev_t; // kind: 0 reg,1 store,2 redirect,3 exc
  ev_t expq[$];

  always #2.5 clk = ~clk;

  rob_core uut (.*);

  task automatic check(input logic ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(); @(posedge clk); #1; endtask

  task automatic expect_ev(input int k, input int a, input int b);
    ev_t e; e.kind = k; e.a = a; e.b = b; expq.push_back(e);
  endtask

  task automatic alloc(input logic [1:0] k, input int dest, output int tag);
    alloc_valid = 1; alloc_kind = k; alloc_dest = 5'(dest);
    #1;
    check(alloc_ready == 1, "R3 ready", alloc_ready, 1);
    check(alloc_tag == 3'(next_tag), "R2 tag", alloc_tag, next_tag);
    tag = next_tag; next_tag = (next_tag + 1) % 8;
    @(posedge clk); #1;
    alloc_valid = 0;
  endtask

  task automatic complete(input int tag, input int val, input int addr,
                          input logic misp, input logic flt);
    done_valid = 1; done_tag = 3'(tag); done_value = val; done_addr = addr;
    done_mispredict = misp; done_fault = flt;
    tick();
    done_valid = 0; done_mispredict = 0; done_fault = 0;
  endtask

  // monitor: scoreboard compare on every retire output
  always @(negedge clk) begin
    if (rst_n && (reg_we || st_release || redirect || exc_valid)) begin
      ev_t e; int k;
      k = reg_we ? 0 : st_release ? 1 : redirect ? 2 : 3;
      if (expq.size() == 0) begin
        check(0, "R4 unexpected retire", k, -1);
      end else begin
        e = expq.pop_front();
        check(k == e.kind, "R4 retire kind", k, e.kind);
        if (e.kind == 0) begin
          check(reg_dest == 5'(e.a), "R6 dest", reg_dest, e.a);
          check(reg_value == e.b, "R6 value", reg_value, e.b);
        end else if (e.kind == 1) begin
          check(st_addr == e.a, "R7 addr", st_addr, e.a);
          check(st_data == e.b, "R7 data", st_data, e.b);
          check(reg_we == 0, "R7 no reg write", reg_we, 0);
        end else if (e.kind == 3) begin
          check(exc_tag == 3'(e.a), "R10 exc tag", exc_tag, e.a);
        end
      end
    end
  end

  initial begin
    while (!done_flag) begin
      @(posedge clk); cycles++;
      if (cycles > 20000) begin
        check(0, "watchdog", cycles, 20000);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    int t0, t1, t2, ta, tb, tc, td, te, tf, tg, tx;
    int tags[8];
    repeat (3) tick();
    rst_n = 1;
    tick();
    // R1 reset state
    check(alloc_ready == 1, "R1 ready", alloc_ready, 1);
    check(alloc_tag == 0, "R1 tag", alloc_tag, 0);
    check({reg_we, st_release, redirect, exc_valid} == 0, "R1 idle", 0, 0);

    // R4/R8: out-of-order completion, in-order retire
    alloc(2'b00, 5, t0); alloc(2'b00, 6, t1); alloc(2'b00, 7, t2);
    expect_ev(0, 5, 11); expect_ev(0, 6, 22); expect_ev(0, 7, 33);
    complete(t2, 33, 0, 0, 0);
    lookup_tag = 3'(t2); #0.5;
    check(lookup_hit == 1, "R8 hit", lookup_hit, 1);
    check(lookup_value == 33, "R8 value", lookup_value, 33);
    lookup_tag = 3'(t1); #0.5;
    check(lookup_hit == 0, "R8 pending miss", lookup_hit, 0);
    repeat (3) tick();
    check(expq.size() == 3, "R4 head waits", expq.size(), 3);
    complete(t0, 11, 0, 0, 0);
    complete(t1, 22, 0, 0, 0);
    repeat (3) tick();
    check(expq.size() == 0, "R4 drained", expq.size(), 0);
    lookup_tag = 3'(t0); #0.5;
    check(lookup_hit == 0, "R8 retired miss", lookup_hit, 0);

    // R3 full, R5 back-to-back retire
    for (int i = 0; i < 8; i++) begin
      int tt; alloc(2'b00, 10 + i, tt); tags[i] = tt;
      expect_ev(0, 10 + i, 100 + i);
    end
    #0.5;
    check(alloc_ready == 0, "R3 full", alloc_ready, 0);
    alloc_valid = 1; alloc_dest = 31; repeat (2) tick(); alloc_valid = 0;
    for (int i = 7; i >= 1; i--) complete(tags[i], 100 + i, 0, 0, 0);
    check(expq.size() == 8, "R4 no retire before head", expq.size(), 8);
    complete(tags[0], 100, 0, 0, 0);
    repeat (4) tick();
    check(expq.size() == 4, "R5 one per cycle", expq.size(), 4);
    repeat (4) tick();
    check(expq.size() == 0, "R5 run done", expq.size(), 0);

    // R7 store
    alloc(2'b01, 0, tx);
    expect_ev(1, 32'h400, 32'hBEEF);
    complete(tx, 32'hBEEF, 32'h400, 0, 0);
    repeat (2) tick();
    check(expq.size() == 0, "R7 store released", expq.size(), 0);

    // R9 mispredict
    alloc(2'b00, 1, ta); alloc(2'b10, 0, tb); alloc(2'b00, 2, tc); alloc(2'b00, 3, td);
    expect_ev(0, 1, 55); expect_ev(2, 0, 0);
    complete(tc, 66, 0, 0, 0); complete(td, 77, 0, 0, 0);
    complete(ta, 55, 0, 0, 0);
    complete(tb, 0, 0, 1, 0);
    repeat (3) tick();
    check(expq.size() == 0, "R9 redirect seen", expq.size(), 0);
    lookup_tag = 3'(tc); #0.5;
    check(lookup_hit == 0, "R9 younger discarded", lookup_hit, 0);
    next_tag = (tb + 1) % 8;
    // correctly predicted branch: silent
    alloc(2'b10, 0, ta); alloc(2'b00, 4, tb);
    expect_ev(0, 4, 88);
    complete(ta, 0, 0, 0, 0); complete(tb, 88, 0, 0, 0);
    repeat (3) tick();
    check(expq.size() == 0, "R9 good branch", expq.size(), 0);

    // R10 exception at head only
    alloc(2'b00, 8, te); alloc(2'b00, 9, tf); alloc(2'b00, 12, tg);
    complete(tf, 0, 0, 0, 1);
    repeat (3) tick();
    check(exc_valid == 0, "R10 not at head", exc_valid, 0);
    expect_ev(0, 8, 5); expect_ev(3, tf, 0);
    complete(tg, 9, 0, 0, 0);
    complete(te, 5, 0, 0, 0);
    repeat (3) tick();
    check(expq.size() == 0, "R10 exc taken", expq.size(), 0);
    next_tag = (tf + 1) % 8;

    // R11 stale completion ignored
    complete(tg, 999, 0, 0, 0);
    alloc(2'b00, 13, tx);
    check(tx == tg, "R11 tag reuse", tx, tg);
    lookup_tag = 3'(tx); #0.5;
    check(lookup_hit == 0, "R11 fresh entry", lookup_hit, 0);
    repeat (3) tick();
    check(expq.size() == 0, "R11 no retire", expq.size(), 0);
    expect_ev(0, 13, 1234);
    complete(tx, 1234, 0, 0, 0);
    repeat (2) tick();
    check(expq.size() == 0, "R11 retire after completion", expq.size(), 0);

    done_flag = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule